// File: doc/BRIEF.md
# Frame Memory Streaming Controller

This block walks an image held in an on-chip RAM that is 32 bits wide and holds two 16-bit pixels per word. It reads each word, sends the pixels into an external processing chain, takes the processed pixels back and writes them into the same word. The image therefore ends up transformed in place. A one-cycle start pulse begins a walk at word address 0. The walk covers `ceil(width*height/2)` words, and then a done flag is raised.

The variant is chosen by a parameter. The serial variant handles the low pixel and then the high pixel of each word through one chain lane, as a camera stream would. The dual variant sends both pixels of a word through two chain lanes at the same time, which almost halves the frame time. The RAM, with one cycle of read latency and byte-lane write enables, sits outside the block. So does the chain, which may have zero or one cycle of latency.

Top module: `fmem_walker`

## Requirements
- R1: A start pulse seen while idle begins a walk at word address 0 and raises `busy` on the next cycle. A start pulse seen while `busy` is high has no effect on the walk, its timing or the memory result.
- R2: In serial mode every full word takes 9 cycles, in this order: address step (no write), low read ×2, low write ×2, high read ×2, high write ×2. A frame of N words with an even pixel count keeps `busy` high for exactly 9·N cycles.
- R3: In dual mode every word takes 5 cycles: address step, read ×2, write ×2. Both half-words pass through the two chain lanes together and are written back as one word, so `busy` lasts 5·N cycles.
- R4: `mem_we` is high only in write steps. Each write step lasts exactly two consecutive cycles, with address, data and byte enables held stable. Per frame there are 2·(pixels) write cycles in serial mode and 2·N in dual mode.
- R5: The walk covers word addresses 0 to N−1 in ascending order, where N = ceil(width·height/2). Words at N and above are not modified.
- R6: In serial mode a low write uses byte enables `0011` (bits 15:0) and a high write uses `1100` (bits 31:16). The low pixel is bits 15:0 of a word.
- R7: When the pixel count is odd, the high half of the last word keeps its old value. In serial mode its high read and high write steps are skipped, so the last word takes 5 cycles. In dual mode the last word is written with byte enables `0011`.
- R8: The chain result is captured in the second cycle of each read step, so a chain with one register stage gives correct write-back data.
- R9: `done` rises after the last write step and stays high until the next accepted start, which clears it. `busy` and `done` are never high together.
- R10: A frame with zero pixels (width or height 0) sets `done` straight from idle, with no busy cycles and no writes.
- R11: While reset is held, the block is idle with `busy`, `done` and `mem_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Walk request pulse |
| frame_w | input | DIM_W | Image width in pixels |
| frame_h | input | DIM_W | Image height in pixels |
| mem_addr | output | ADDR_W | RAM word address |
| mem_rdata | input | 32 | RAM read data, one cycle after the address |
| mem_we | output | 1 | RAM write enable |
| mem_be | output | 4 | RAM byte-lane enables |
| mem_wdata | output | 32 | RAM write data |
| pix_out_lo | output | 16 | Pixel to chain lane 0 (serial: current half) |
| pix_out_hi | output | 16 | Pixel to chain lane 1 (high half) |
| pix_in_lo | input | 16 | Result from chain lane 0 |
| pix_in_hi | input | 16 | Result from chain lane 1 (dual mode) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Last frame completed |

## Verification
The bench builds two instances side by side, one with `DUAL=0` and one with `DUAL=1`, both with `DIM_W=5` and `ADDR_W=6`. A 64-word RAM then holds the largest frame used (7×9, 32 words) as well as guard words above it. The chain in the bench has one register stage and a transform that is not its own inverse. This exposes any capture-timing slip, any processed word that is skipped and any word that is processed twice. The small dimensions make odd pixel counts, single-pixel frames, zero-size frames and a restart attempt in the middle of a frame cheap to run.

// File: rtl/fmw_pkg.sv
package fmw_pkg;

    localparam int PIX_W  = 16;
    localparam int LANES  = 2;
    localparam int WORD_W = PIX_W * LANES;
    localparam int BE_W   = WORD_W / 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADV,
        ST_RDA1,
        ST_RDA2,
        ST_WRA1,
        ST_WRA2,
        ST_RDB1,
        ST_RDB2,
        ST_WRB1,
        ST_WRB2
    } walk_st_e;

    typedef struct packed {
        logic rd;     // read step
        logic wr;     // write step
        logic late;   // second cycle of a step
        logic upper;  // high half-word phase (serial)
    } step_t;

    function automatic step_t step_of(walk_st_e s);
        step_t t;
        t.rd    = (s == ST_RDA1) || (s == ST_RDA2) || (s == ST_RDB1) || (s == ST_RDB2);
        t.wr    = (s == ST_WRA1) || (s == ST_WRA2) || (s == ST_WRB1) || (s == ST_WRB2);
        t.late  = (s == ST_RDA2) || (s == ST_RDB2) || (s == ST_WRA2) || (s == ST_WRB2);
        t.upper = (s == ST_RDB1) || (s == ST_RDB2) || (s == ST_WRB1) || (s == ST_WRB2);
        return t;
    endfunction

    // Successor within a word; word-end decisions are taken by the sequencer.
    function automatic walk_st_e seq_next(walk_st_e s);
        case (s)
            ST_ADV:  return ST_RDA1;
            ST_RDA1: return ST_RDA2;
            ST_RDA2: return ST_WRA1;
            ST_WRA1: return ST_WRA2;
            ST_WRA2: return ST_RDB1;
            ST_RDB1: return ST_RDB2;
            ST_RDB2: return ST_WRB1;
            ST_WRB1: return ST_WRB2;
            default: return ST_IDLE;
        endcase
    endfunction

    function automatic logic [BE_W-1:0] half_be(logic upper);
        return upper ? {{(BE_W/2){1'b1}}, {(BE_W/2){1'b0}}}
                     : {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
    endfunction

endpackage

// File: rtl/fmw_seq.sv
module fmw_seq
    import fmw_pkg::*;
#(
    parameter int DUAL   = 0,
    parameter int DIM_W  = 10,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIM_W-1:0]  frame_w,
    input  logic [DIM_W-1:0]  frame_h,
    output walk_st_e          state,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic              last_odd
);

    localparam int CNT_W = 2 * DIM_W;

    logic [CNT_W-1:0]  pix_cnt;
    logic [CNT_W-1:0]  word_tot;
    walk_st_e          st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  last_q;
    logic              odd_q;
    logic              done_q;
    logic              is_last;
    logic              word_end;

    assign pix_cnt  = CNT_W'(frame_w) * CNT_W'(frame_h);
    assign word_tot = (pix_cnt >> 1) + CNT_W'(pix_cnt[0]);
    assign is_last  = (idx_q == last_q);

    always_comb begin
        word_end = 1'b0;
        if (st_q == ST_WRB2) begin
            word_end = 1'b1;
        end else if (st_q == ST_WRA2) begin
            word_end = (DUAL != 0) || (is_last && odd_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            idx_q  <= '0;
            last_q <= '0;
            odd_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (st_q == ST_IDLE) begin
            if (start) begin
                addr_q <= '0;
                idx_q  <= '0;
                odd_q  <= pix_cnt[0];
                last_q <= word_tot - 1'b1;
                if (word_tot == '0) begin
                    done_q <= 1'b1;
                end else begin
                    done_q <= 1'b0;
                    st_q   <= ST_ADV;
                end
            end
        end else if (word_end) begin
            if (is_last) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
            end else begin
                st_q   <= ST_ADV;
                addr_q <= addr_q + 1'b1;
                idx_q  <= idx_q + 1'b1;
            end
        end else begin
            st_q <= seq_next(st_q);
        end
    end

    assign state    = st_q;
    assign addr     = addr_q;
    assign busy     = (st_q != ST_IDLE);
    assign done     = done_q;
    assign last_odd = is_last && odd_q;

    // R9
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ((addr_q == $past(addr_q)) || (addr_q == $past(addr_q) + 1'b1)));

    // R10
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> ($past(busy) || $past(start)));

    // R1
    walk_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (addr_q == '0));

endmodule

// File: rtl/fmw_capture.sv
module fmw_capture
    import fmw_pkg::*;
#(
    parameter int DUAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic             cap_upper,
    input  logic [PIX_W-1:0] lane0_in,
    input  logic [PIX_W-1:0] lane1_in,
    output logic [PIX_W-1:0] res_lo,
    output logic [PIX_W-1:0] res_hi
);

    generate
        if (DUAL != 0) begin : g_dual
            logic unused_upper;
            assign unused_upper = cap_upper;
            always_ff @(posedge clk) begin
                if (rst) begin
                    res_lo <= '0;
                    res_hi <= '0;
                end else if (cap_en) begin
                    res_lo <= lane0_in;
                    res_hi <= lane1_in;
                end
            end
        end else begin : g_serial
            logic unused_lane1;
            assign unused_lane1 = ^lane1_in;
            always_ff @(posedge clk) begin
                if (rst) begin
                    res_lo <= '0;
                    res_hi <= '0;
                end else if (cap_en) begin
                    if (cap_upper) res_hi <= lane0_in;
                    else           res_lo <= lane0_in;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fmw_wport.sv
module fmw_wport
    import fmw_pkg::*;
#(
    parameter int DUAL = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_step,
    input  logic              upper,
    input  logic              last_odd,
    input  logic [PIX_W-1:0]  res_lo,
    input  logic [PIX_W-1:0]  res_hi,
    output logic              mem_we,
    output logic [BE_W-1:0]   mem_be,
    output logic [WORD_W-1:0] mem_wdata
);

    assign mem_we    = wr_step;
    assign mem_wdata = {res_hi, res_lo};

    generate
        if (DUAL != 0) begin : g_dual
            logic unused_upper;
            assign unused_upper = upper;
            assign mem_be = last_odd ? half_be(1'b0) : {BE_W{1'b1}};
        end else begin : g_serial
            logic unused_last;
            assign unused_last = last_odd;
            assign mem_be = half_be(upper);

            // R6
            serial_half_be_chk: assert property (@(posedge clk) disable iff (rst)
                mem_we |-> ($countones(mem_be) == BE_W / 2));
        end
    endgenerate

    // R4
    we_pair_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |=> mem_we);

    // R4
    we_len_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |=> !mem_we);

    // R4
    wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> ($stable(mem_wdata) && $stable(mem_be)));

endmodule

// File: rtl/fmem_walker.sv
module fmem_walker
    import fmw_pkg::*;
#(
    parameter int DUAL   = 0,
    parameter int DIM_W  = 10,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIM_W-1:0]  frame_w,
    input  logic [DIM_W-1:0]  frame_h,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              mem_we,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    output logic [15:0]       pix_out_lo,
    output logic [15:0]       pix_out_hi,
    input  logic [15:0]       pix_in_lo,
    input  logic [15:0]       pix_in_hi,
    output logic              busy,
    output logic              done
);

    walk_st_e         state;
    step_t            step;
    logic             last_odd;
    logic [PIX_W-1:0] res_lo;
    logic [PIX_W-1:0] res_hi;
    logic             cap_en;

    fmw_seq #(
        .DUAL   (DUAL),
        .DIM_W  (DIM_W),
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .frame_w  (frame_w),
        .frame_h  (frame_h),
        .state    (state),
        .addr     (mem_addr),
        .busy     (busy),
        .done     (done),
        .last_odd (last_odd)
    );

    assign step   = step_of(state);
    assign cap_en = step.rd && step.late;

    // Serial mode feeds the selected half on lane 0; lane 1 always carries the high half.
    assign pix_out_lo = step.upper ? mem_rdata[WORD_W-1:PIX_W] : mem_rdata[PIX_W-1:0];
    assign pix_out_hi = mem_rdata[WORD_W-1:PIX_W];

    fmw_capture #(
        .DUAL (DUAL)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .cap_upper (step.upper),
        .lane0_in  (pix_in_lo),
        .lane1_in  (pix_in_hi),
        .res_lo    (res_lo),
        .res_hi    (res_hi)
    );

    fmw_wport #(
        .DUAL (DUAL)
    ) u_wp (
        .clk       (clk),
        .rst       (rst),
        .wr_step   (step.wr),
        .upper     (step.upper),
        .last_odd  (last_odd),
        .res_lo    (res_lo),
        .res_hi    (res_hi),
        .mem_we    (mem_we),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata)
    );

    // R8
    capture_before_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> $past(cap_en));

endmodule

// File: tb/tb_fmem_walker.sv
`timescale 1ns/1ps

module fmw_tb_ram #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_a,
    input  logic [31:0]   ld_d,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [3:0]    be,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    logic [31:0] mem [0:(1<<AW)-1];

    always @(posedge clk) begin
        rdata <= mem[addr];
        if (ld_en) begin
            mem[ld_a] <= ld_d;
        end else if (we) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) mem[addr][8*b +: 8] <= wdata[8*b +: 8];
        end
    end
endmodule

module tb_fmem_walker;

    localparam int DIM_W  = 5;
    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NVEC   = 7;

    // {width[25:21], height[20:16], seed[15:0]}
    localparam logic [25:0] VEC [0:NVEC-1] = '{
        {5'd4, 5'd2, 16'h1234},
        {5'd3, 5'd3, 16'hBEEF},
        {5'd1, 5'd1, 16'h0F0F},
        {5'd7, 5'd9, 16'h7A51},
        {5'd8, 5'd4, 16'hC0DE},
        {5'd0, 5'd5, 16'h4242},
        {5'd6, 5'd1, 16'h9001}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [DIM_W-1:0] fw = '0;
    logic [DIM_W-1:0] fh = '0;
    logic ld_en = 1'b0;
    logic [ADDR_W-1:0] ld_a = '0;
    logic [31:0] ld_d = '0;

    logic [ADDR_W-1:0] addr_s, addr_d;
    logic [31:0] rdata_s, rdata_d, wdata_s, wdata_d;
    logic we_s, we_d, busy_s, busy_d, done_s, done_d;
    logic [3:0] be_s, be_d;
    logic [15:0] pol_s, poh_s, pil_s, pih_s;
    logic [15:0] pol_d, poh_d, pil_d, pih_d;

    logic [31:0] orig [0:DEPTH-1];
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] fx(logic [15:0] p);
        return (p ^ 16'hA5C3) + 16'd7;
    endfunction

    function automatic logic [31:0] gen(logic [15:0] s, int i);
        logic [15:0] a, b;
        a = s ^ 16'(i * 4951);
        b = 16'(~s) + 16'(i * 2989);
        return {b, a};
    endfunction

    // one-stage registered chain, both instances, both lanes
    always @(posedge clk) begin
        pil_s <= fx(pol_s);
        pih_s <= fx(poh_s);
        pil_d <= fx(pol_d);
        pih_d <= fx(poh_d);
    end

    fmem_walker #(.DUAL(0), .DIM_W(DIM_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .start(start), .frame_w(fw), .frame_h(fh),
        .mem_addr(addr_s), .mem_rdata(rdata_s), .mem_we(we_s), .mem_be(be_s),
        .mem_wdata(wdata_s), .pix_out_lo(pol_s), .pix_out_hi(poh_s),
        .pix_in_lo(pil_s), .pix_in_hi(pih_s), .busy(busy_s), .done(done_s)
    );

    fmem_walker #(.DUAL(1), .DIM_W(DIM_W), .ADDR_W(ADDR_W)) dut_dual (
        .clk(clk), .rst(rst), .start(start), .frame_w(fw), .frame_h(fh),
        .mem_addr(addr_d), .mem_rdata(rdata_d), .mem_we(we_d), .mem_be(be_d),
        .mem_wdata(wdata_d), .pix_out_lo(pol_d), .pix_out_hi(poh_d),
        .pix_in_lo(pil_d), .pix_in_hi(pih_d), .busy(busy_d), .done(done_d)
    );

    fmw_tb_ram #(.AW(ADDR_W)) ram_s (
        .clk(clk), .ld_en(ld_en), .ld_a(ld_a), .ld_d(ld_d), .addr(addr_s),
        .we(we_s), .be(be_s), .wdata(wdata_s), .rdata(rdata_s)
    );

    fmw_tb_ram #(.AW(ADDR_W)) ram_d (
        .clk(clk), .ld_en(ld_en), .ld_a(ld_a), .ld_d(ld_d), .addr(addr_d),
        .we(we_d), .be(be_d), .wdata(wdata_d), .rdata(rdata_d)
    );

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load_frame(logic [15:0] seed);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            orig[i] = gen(seed, i);
            ld_en = 1'b1;
            ld_a  = ADDR_W'(i);
            ld_d  = orig[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic mem_chk(string tag, bit dual_side, int w, int h);
        int pix, words, bad, first;
        logic [31:0] exp_w, act_w, fe, fa;
        pix = w * h;
        words = (pix + 1) / 2;
        bad = 0;
        first = -1;
        fe = '0;
        fa = '0;
        for (int i = 0; i < DEPTH; i++) begin
            exp_w = orig[i];
            if (i < words) begin
                exp_w[15:0] = fx(orig[i][15:0]);
                if (!((pix % 2 == 1) && (i == words - 1)))
                    exp_w[31:16] = fx(orig[i][31:16]);
            end
            act_w = dual_side ? ram_d.mem[i] : ram_s.mem[i];
            if (act_w !== exp_w) begin
                bad++;
                if (first < 0) begin
                    first = i;
                    fe = exp_w;
                    fa = act_w;
                end
            end
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s: word %0d actual %h expected %h (%0d bad words)",
                     tag, first, fa, fe, bad);
        end
    endtask

    int cyc_s, cyc_d, wec_s, wec_d, low_s;
    bit done_at0_s, done_at0_d, busy_at0_s;

    // Pulses start, then samples every cycle until both instances are idle.
    task automatic run_frame(int w, int h, bit restart_mid);
        int k;
        fw = DIM_W'(w);
        fh = DIM_W'(h);
        cyc_s = 0; cyc_d = 0; wec_s = 0; wec_d = 0; low_s = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        forever begin
            if (k == 0) begin
                done_at0_s = done_s;
                done_at0_d = done_d;
                busy_at0_s = busy_s;
            end
            if (busy_s) cyc_s++;
            if (busy_d) cyc_d++;
            if (we_s) wec_s++;
            if (we_d) wec_d++;
            if (we_s && be_s == 4'b0011) low_s++;
            if (!busy_s && !busy_d) break;
            start = restart_mid && (k == 6);
            @(negedge clk);
            k++;
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11 busy in reset", int'(busy_s) + int'(busy_d), 0);
        chk("R11 done/we in reset", int'(done_s) + int'(done_d) + int'(we_s) + int'(we_d), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            int w, h, pix, words, exp_s;
            w = int'(VEC[v][25:21]);
            h = int'(VEC[v][20:16]);
            pix = w * h;
            words = (pix + 1) / 2;
            exp_s = 9 * words - ((pix % 2 == 1) ? 4 : 0);
            load_frame(VEC[v][15:0]);
            run_frame(w, h, 1'b0);
            // R2 / R7 / R10: serial frame length
            chk("R2 R7 R10 serial busy cycles", cyc_s, exp_s);
            // R3: dual frame length
            chk("R3 dual busy cycles", cyc_d, 5 * words);
            // R4: write cycle counts
            chk("R4 serial write cycles", wec_s, 2 * pix);
            chk("R4 dual write cycles", wec_d, 2 * words);
            // R6: low half writes use bytes 1:0
            chk("R6 serial low-half writes", low_s, 2 * words);
            // R9: done held after frame
            chk("R9 done after frame", int'(done_s && done_d && !busy_s && !busy_d), 1);
            // R5 R7 R8: in-place result, odd tail, guard words
            mem_chk("R5 R7 R8 serial memory", 1'b0, w, h);
            mem_chk("R3 R5 R7 dual memory", 1'b1, w, h);
        end

        // R1: start while busy is ignored
        load_frame(16'h5EED);
        run_frame(5, 3, 1'b1);
        chk("R1 serial cycles with mid-frame start", cyc_s, 9 * 8 - 4);
        chk("R1 dual cycles with mid-frame start", cyc_d, 5 * 8);
        mem_chk("R1 serial memory with mid-frame start", 1'b0, 5, 3);
        mem_chk("R1 dual memory with mid-frame start", 1'b1, 5, 3);

        // R9: an accepted start clears done
        load_frame(16'h0A0A);
        run_frame(2, 2, 1'b0);
        chk("R9 done cleared on next start", int'(done_at0_s) + int'(done_at0_d), 0);
        chk("R1 busy one cycle after start", int'(busy_at0_s), 1);
        mem_chk("R5 serial memory 2x2", 1'b0, 2, 2);

        // R10: zero-height frame after a real one
        load_frame(16'h3C3C);
        run_frame(9, 0, 1'b0);
        chk("R10 zero frame busy cycles", cyc_s + cyc_d, 0);
        chk("R10 zero frame writes", wec_s + wec_d, 0);
        chk("R10 zero frame done", int'(done_s && done_d), 1);
        mem_chk("R10 zero frame memory", 1'b0, 9, 0);

        summary();
        $finish;
    end

endmodule